// File: doc/BRIEF.md
# Factory Programming Phase Sequencer

This block runs one high-throughput programming session of a flash array model. A single start pulse and a word-aligned start address open the session. The session first passes a setup gate. That gate checks three things: a programming-supply flag, a block-lock flag, and the alignment of the start address to a 1 KB programming region. When the gate passes, the block takes user words over a valid/ready stream into a write buffer. Each time the buffer fills, or the stream marks its final word, the buffered words go into the array one per cycle at consecutive addresses. No request from outside is needed for this.

Each word is programmed and checked in the same step. The array model acts like real flash: programming can only clear bits, and an erased cell reads all ones. The block compares the value the cell ends up holding with the value that was requested. The session always ends with an exit check. This check moves any error gathered during the session into the status byte, and only then does the block report ready. A word that fails the compare does not stop programming. The rest of the stream is still written.

The array can be read back through a registered read port, so the stored contents can be inspected.

Top module: `fastprog_seq`

## Requirements
- R1: After reset, status reads 0x80 (ready, no errors), busy is 0 and din_ready is 0. Every array word reads as all ones.
- R2: A start pulse while idle raises busy on the next clock edge. While the session runs, status reads 0x00: bit 7 (ready) is 0 and all error bits are cleared.
- R3: If vpp_ok is low when setup is evaluated, the session ends with status 0x88 (bit 3, supply error). No data word is accepted and the array is unchanged. The supply error wins over the other two setup checks.
- R4: If the supply is good and blk_locked is high, the session ends with status 0x82 (bit 1, lock error). No data is accepted and the array is unchanged. The lock error wins over the alignment check.
- R5: If the supply and lock checks pass but start_addr has any of its low 9 bits set (not on a 512-word, 1 KB region boundary), the session ends with status 0xA0 (bit 5, sequence error). No data is accepted.
- R6: The k-th accepted word (counting from 0) is programmed at start_addr + k, wrapping modulo the array depth. The cell becomes its previous value AND the word. A read issued through rd_addr returns on rd_data one cycle later.
- R7: At most BUF_WORDS (default 32) words are accepted between buffer commits. din_ready goes low once the buffer holds BUF_WORDS words and stays low until the buffer has been written to the array.
- R8: If any programmed word reads back different from the requested word, the session ends with status 0x90 (bit 4, program error). All remaining words of the stream are still accepted and programmed.
- R9: busy stays high from the start pulse until the exit check completes. Status bit 7 is 0 for that whole time. din_ready is never high while the block is idle.
- R10: A start pulse while a session is running is ignored. The running session keeps its own addresses, and no array word at the new address changes.
- R11: A word accepted with din_last high ends the stream. The partly filled buffer is committed, and then the session exits with status 0x80 if there were no errors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to open a session |
| start_addr | input | ADDR_W | First word address of the session |
| vpp_ok | input | 1 | Elevated programming supply is present |
| blk_locked | input | 1 | Target block is locked |
| din | input | DATA_W | Stream data word |
| din_valid | input | 1 | Stream word is valid |
| din_last | input | 1 | Marks the final word of the stream |
| din_ready | output | 1 | Block accepts a stream word this cycle |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word, one cycle after rd_addr |
| busy | output | 1 | Session in progress |
| status | output | 8 | Bit 7 ready, bit 5 sequence, bit 4 program, bit 3 supply, bit 1 lock error |

## Verification
The assertions assume that start is only a short pulse and that vpp_ok, blk_locked and start_addr are steady in the cycle that setup samples them. They also assume din_last only arrives together with a valid word. The stimulus sets the supply, lock and address before the start pulse and holds them for the whole session. It marks only the final word of each stream as last, and it stalls din_valid at random so that commits land between words as well as right after a word. A second session over an already programmed region produces real read-back mismatches, without forcing any internal signal.

// File: rtl/fastprog_pkg.sv
package fastprog_pkg;

    localparam int STAT_W  = 8;
    localparam int SB_RDY  = 7;
    localparam int SB_SEQ  = 5;
    localparam int SB_PGM  = 4;
    localparam int SB_VPP  = 3;
    localparam int SB_LOCK = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_FILL,
        S_COMMIT,
        S_EXIT
    } phase_t;

    typedef enum logic [1:0] {
        CHK_OK,
        CHK_VPP,
        CHK_LOCK,
        CHK_ALIGN
    } setup_res_t;

    typedef struct packed {
        logic seq;
        logic pgm;
        logic vpp;
        logic lock;
    } err_t;

    // Setup gate order: supply first, then lock, then alignment.
    function automatic setup_res_t setup_check(input logic vpp_ok,
                                               input logic locked,
                                               input logic aligned);
        if (!vpp_ok)       return CHK_VPP;
        else if (locked)   return CHK_LOCK;
        else if (!aligned) return CHK_ALIGN;
        else               return CHK_OK;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic ready,
                                                      input err_t e);
        logic [STAT_W-1:0] s;
        s          = '0;
        s[SB_RDY]  = ready;
        s[SB_SEQ]  = e.seq;
        s[SB_PGM]  = e.pgm;
        s[SB_VPP]  = e.vpp;
        s[SB_LOCK] = e.lock;
        return s;
    endfunction

endpackage

// File: rtl/fastprog_wbuf.sv
module fastprog_wbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    logic [DATA_W-1:0] slot [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_en && (count == CNT_W'(g))) begin
                    slot[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr_en) begin
            count <= count + 1'b1;
        end
    end

    assign rd_data = slot[rd_idx];
    assign full    = (count == CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < CNT_W'(DEPTH)));

    // R7
    no_clear_write_chk: assert property (@(posedge clk) disable iff (rst)
        clear |-> !wr_en);

endmodule

// File: rtl/fastprog_array.sv
module fastprog_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    output logic              vfail,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] cell_next;

    // Programming can only clear bits; the compare is made on the result.
    assign cell_next = mem[pgm_addr] & pgm_data;
    assign vfail     = pgm_en && (cell_next != pgm_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (pgm_en) begin
            mem[pgm_addr] <= cell_next;
        end
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

    // R8
    verify_flag_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_en |=> ((mem[$past(pgm_addr)] != $past(pgm_data)) == $past(vfail)));

endmodule

// File: rtl/fastprog_ctrl.sv
module fastprog_ctrl
    import fastprog_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int BUF_WORDS  = 32,
    parameter int ALIGN_BITS = 9,
    localparam int IDX_W     = $clog2(BUF_WORDS),
    localparam int CNT_W     = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              vpp_ok,
    input  logic              blk_locked,
    input  logic              din_valid,
    input  logic              din_last,
    output logic              din_ready,
    output logic              buf_wr_en,
    output logic              buf_clear,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic              buf_full,
    output logic [IDX_W-1:0]  buf_rd_idx,
    output logic              pgm_en,
    output logic [ADDR_W-1:0] pgm_addr,
    input  logic              vfail,
    output logic              busy,
    output logic [STAT_W-1:0] status
);

    phase_t             state;
    logic [ADDR_W-1:0]  base_addr;
    logic [IDX_W-1:0]   cidx;
    logic               last_seen;
    err_t               pend;
    err_t               flags;
    logic               aligned;
    logic               commit_done;

    assign aligned = (base_addr[ALIGN_BITS-1:0] == '0);

    always_comb begin
        din_ready   = (state == S_FILL) && !buf_full;
        buf_wr_en   = din_ready && din_valid;
        pgm_en      = (state == S_COMMIT);
        buf_rd_idx  = cidx;
        pgm_addr    = base_addr + ADDR_W'(cidx);
        commit_done = pgm_en && (CNT_W'(cidx) == (buf_count - 1'b1));
        buf_clear   = commit_done;
        busy        = (state != S_IDLE);
        status      = pack_status(!busy, flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            base_addr <= '0;
            cidx      <= '0;
            last_seen <= 1'b0;
            pend      <= '0;
            flags     <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    cidx <= '0;
                    if (start) begin
                        base_addr <= start_addr;
                        pend      <= '0;
                        flags     <= '0;
                        last_seen <= 1'b0;
                        state     <= S_SETUP;
                    end
                end
                S_SETUP: begin
                    case (setup_check(vpp_ok, blk_locked, aligned))
                        CHK_OK:    state <= S_FILL;
                        CHK_VPP:   begin pend.vpp  <= 1'b1; state <= S_EXIT; end
                        CHK_LOCK:  begin pend.lock <= 1'b1; state <= S_EXIT; end
                        default:   begin pend.seq  <= 1'b1; state <= S_EXIT; end
                    endcase
                end
                S_FILL: begin
                    if (buf_wr_en &&
                        (din_last || buf_count == CNT_W'(BUF_WORDS - 1))) begin
                        state     <= S_COMMIT;
                        cidx      <= '0;
                        last_seen <= din_last;
                    end
                end
                S_COMMIT: begin
                    if (vfail) begin
                        pend.pgm <= 1'b1;
                    end
                    if (commit_done) begin
                        base_addr <= base_addr + ADDR_W'(buf_count);
                        cidx      <= '0;
                        state     <= last_seen ? S_EXIT : S_FILL;
                    end else begin
                        cidx <= cidx + 1'b1;
                    end
                end
                S_EXIT: begin
                    flags <= pend;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start) |=> (state == S_SETUP && status == '0));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && state != S_EXIT) |=> busy);

    // R3
    supply_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SETUP && !vpp_ok) |=> (state == S_EXIT && pend.vpp && !pend.lock));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FILL && start && !buf_wr_en) |=> (state == S_FILL && $stable(base_addr)));

    // R11
    last_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr_en && din_last) |=> (state == S_COMMIT && last_seen));

    // R9
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !din_ready);

endmodule

// File: rtl/fastprog_seq.sv
module fastprog_seq
    import fastprog_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 11,
    parameter int BUF_WORDS    = 32,
    parameter int REGION_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              vpp_ok,
    input  logic              blk_locked,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic              din_last,
    output logic              din_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [7:0]        status
);

    localparam int REGION_WORDS = REGION_BYTES / (DATA_W / 8);
    localparam int ALIGN_BITS   = $clog2(REGION_WORDS);
    localparam int IDX_W        = $clog2(BUF_WORDS);
    localparam int CNT_W        = $clog2(BUF_WORDS + 1);

    logic              buf_wr_en;
    logic              buf_clear;
    logic [CNT_W-1:0]  buf_count;
    logic              buf_full;
    logic [IDX_W-1:0]  buf_rd_idx;
    logic [DATA_W-1:0] buf_rd_data;
    logic              pgm_en;
    logic [ADDR_W-1:0] pgm_addr;
    logic              vfail;

    fastprog_ctrl #(
        .ADDR_W    (ADDR_W),
        .BUF_WORDS (BUF_WORDS),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_addr(start_addr),
        .vpp_ok    (vpp_ok),
        .blk_locked(blk_locked),
        .din_valid (din_valid),
        .din_last  (din_last),
        .din_ready (din_ready),
        .buf_wr_en (buf_wr_en),
        .buf_clear (buf_clear),
        .buf_count (buf_count),
        .buf_full  (buf_full),
        .buf_rd_idx(buf_rd_idx),
        .pgm_en    (pgm_en),
        .pgm_addr  (pgm_addr),
        .vfail     (vfail),
        .busy      (busy),
        .status    (status)
    );

    fastprog_wbuf #(
        .DATA_W(DATA_W),
        .DEPTH (BUF_WORDS)
    ) u_wbuf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (buf_wr_en),
        .wr_data(din),
        .clear  (buf_clear),
        .rd_idx (buf_rd_idx),
        .rd_data(buf_rd_data),
        .count  (buf_count),
        .full   (buf_full)
    );

    fastprog_array #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .pgm_en  (pgm_en),
        .pgm_addr(pgm_addr),
        .pgm_data(buf_rd_data),
        .vfail   (vfail),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R1
    reset_ready_chk: assert property (@(posedge clk)
        $past(rst) |-> (status == 8'h80 && !busy));

endmodule

// File: tb/fastprog_seq_test.sv
module fastprog_seq_test;

    localparam int DW    = 16;
    localparam int AW    = 11;
    localparam int BW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam int RW    = 512;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] start_addr;
    logic          vpp_ok;
    logic          blk_locked;
    logic [DW-1:0] din;
    logic          din_valid;
    logic          din_last;
    logic          din_ready;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int max_run;
    int accepted;

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] wq  [128];

    always #10 clk = ~clk;

    fastprog_seq uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_addr(start_addr),
        .vpp_ok    (vpp_ok),
        .blk_locked(blk_locked),
        .din       (din),
        .din_valid (din_valid),
        .din_last  (din_last),
        .din_ready (din_ready),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .status    (status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=busy expected=idle");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] exp_setup(input logic vpp, input logic lk,
                                             input logic [AW-1:0] a);
        if (!vpp)             return 8'h88;
        else if (lk)          return 8'h82;
        else if (a[8:0] != 0) return 8'hA0;
        else                  return 8'h00;
    endfunction

    task automatic fill_random(input int n);
        for (int k = 0; k < n; k++) wq[k] = DW'($urandom);
    endtask

    task automatic readback(input int a0, input int cnt, input string req);
        for (int k = 0; k < cnt; k++) begin
            rd_addr = AW'((a0 + k) % DEPTH);
            @(negedge clk);
            chk(req, rd_data, mdl[(a0 + k) % DEPTH]);
        end
    endtask

    task automatic session(input logic [AW-1:0] addr, input int n, input logic vpp,
                           input logic lk, input bit poke);
        int   idx  = 0;
        int   iter = 0;
        int   run  = 0;
        bit   pf   = 0;
        logic [7:0] es;
        logic [DW-1:0] nw;
        vpp_ok     = vpp;
        blk_locked = lk;
        start_addr = addr;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy", {31'b0, busy}, 32'd1);
        chk("R2 status", {24'b0, status}, 32'h00);
        max_run = 0;
        while (busy) begin
            if (poke && iter == 5) begin
                start      = 1'b1;
                start_addr = addr ^ AW'(RW);
            end else begin
                start      = 1'b0;
                start_addr = addr;
            end
            if (idx < n) begin
                din_valid = ($urandom % 4) != 0;
                din       = wq[idx];
                din_last  = (idx == n - 1);
            end else begin
                din_valid = 1'b0;
                din_last  = 1'b0;
            end
            if (!din_ready) begin
                run = 0;
            end else if (din_valid) begin
                run++;
                idx++;
                if (run > max_run) max_run = run;
                if (run > BW) begin
                    errors++;
                    checks++;
                    $display("FAIL R7 actual=%0d expected<=%0d", run, BW);
                end
            end
            @(negedge clk);
            iter++;
        end
        din_valid = 1'b0;
        din_last  = 1'b0;
        start     = 1'b0;
        accepted  = idx;
        es = exp_setup(vpp, lk, addr);
        if (es != 8'h00) begin
            chk("R3/R4/R5 no data accepted", accepted, 0);
            chk(es == 8'h88 ? "R3 status" : (es == 8'h82 ? "R4 status" : "R5 status"),
                {24'b0, status}, {24'b0, es});
        end else begin
            for (int k = 0; k < n; k++) begin
                nw = mdl[(addr + k) % DEPTH] & wq[k];
                if (nw != wq[k]) pf = 1;
                mdl[(addr + k) % DEPTH] = nw;
            end
            chk("R11 all words accepted", accepted, n);
            chk(pf ? "R8 status" : "R6 status", {24'b0, status}, pf ? 32'h90 : 32'h80);
        end
        chk("R9 ready after exit", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst        = 1'b1;
        start      = 1'b0;
        start_addr = '0;
        vpp_ok     = 1'b0;
        blk_locked = 1'b0;
        din        = '0;
        din_valid  = 1'b0;
        din_last   = 1'b0;
        rd_addr    = '0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {24'b0, status}, 32'h80);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 din_ready", {31'b0, din_ready}, 32'd0);
        readback(0, 2, "R1 erased");

        // R3 supply missing, also locked: supply error wins
        fill_random(4);
        session(11'd0, 4, 1'b0, 1'b1, 1'b0);
        readback(0, 4, "R3 untouched");

        // R4 locked, misaligned: lock error wins
        session(11'd7, 4, 1'b1, 1'b1, 1'b0);

        // R5 misaligned start
        session(11'd5, 4, 1'b1, 1'b0, 1'b0);
        readback(0, 8, "R5 untouched");

        // R6/R7 multi-buffer stream
        fill_random(70);
        session(11'd0, 70, 1'b1, 1'b0, 1'b0);
        chk("R7 full buffer run", max_run, BW);
        readback(0, 72, "R6 data");

        // R11 stream ends exactly at buffer boundary
        fill_random(BW);
        session(11'd512, BW, 1'b1, 1'b0, 1'b0);
        readback(512, BW + 2, "R11 data");

        // R10 start pulse mid-session ignored
        fill_random(40);
        session(11'd1024, 40, 1'b1, 1'b0, 1'b1);
        readback(1024, 42, "R10 data");
        readback(1536, 4, "R10 other region");

        // R8 reprogram over written cells
        fill_random(20);
        session(11'd0, 20, 1'b1, 1'b0, 1'b0);
        readback(0, 22, "R8 data");

        // R11 single word stream
        wq[0] = 16'h0000;
        session(11'd1536, 1, 1'b1, 1'b0, 1'b0);
        readback(1535, 3, "R11 single");

        // random sessions
        for (int s = 0; s < 8; s++) begin
            logic [AW-1:0] a;
            int            n;
            a = AW'(($urandom % 4) * RW);
            if ($urandom % 5 == 0) a = a + AW'(1 + $urandom % 511);
            n = 1 + $urandom % 90;
            fill_random(n);
            session(a, n, ($urandom % 6) != 0, ($urandom % 6) == 0, 1'b0);
            readback(a, n, "R6 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule